// File: doc/BRIEF.md
# Buffered-Modulus PWM Period Counter

This block is the time base of a motor-control PWM. A 12-bit counter steps once per clock and describes one PWM period after another. In edge-aligned operation it climbs from 1 to the modulus and restarts at 1. In center-aligned operation it rises from 0 to the modulus and falls back toward 0, which makes a period twice the modulus long. Duty comparators, dead time, fault logic and prescaling sit outside the block and consume its count and direction.

Software writes the modulus as two bytes into a buffer register. A read of those bytes returns the buffer, not the modulus the counter is using. A new modulus only reaches the counter once software raises a load-permit flag and the next period boundary (a load cycle) arrives. At that boundary the flag clears by itself. Each load cycle is marked by a one-clock strobe, and the counting mode is sampled at the same moment. A modulus of zero is illegal: it makes the counter run downward from 0xFFF without end.

Top module: `pwm_period_base`

## Requirements
- R1: A high-byte write stores wrData[3:0] as modulus bits 11..8. A low-byte write stores wrData[7:0] as bits 7..0. rdHi returns {4'b0000, buffer[11:8]} and rdLo returns buffer[7:0]. Both always show the buffer, not the active modulus.
- R2: A buffer write alone never changes activeMod or the count pattern. This holds across load cycles while the load-permit flag is clear.
- R3: In edge-aligned mode (sampled centerSel=0), for modulus M≥1, the count runs 1,2,…,M and then 1 again, so the period is M clocks. dirDown stays 0.
- R4: In center-aligned mode (sampled centerSel=1), for M≥1, the count runs 0,1,…,M,M-1,…,1 and then 0 again, so the period is 2M clocks. dirDown is 1 exactly while the count steps down from M-1 to 1.
- R5: A load cycle is the clock after a period ends. In that cycle loadStb is 1 for exactly one clock, and the count holds the start value: 1 in edge mode, 0 in center mode, 0xFFF for zero modulus. If ldOkFlag was set before that cycle, the buffer moves into activeMod and ldOkFlag clears.
- R6: A ldOkSet pulse in the last clock of a period does not move the buffer at that boundary. ldOkFlag stays 1 and the transfer happens at the following boundary. A buffer write in the last clock of a period is not part of a transfer made at that boundary.
- R7: While enable=0, the count is 0, dirDown is 0 and loadStb is 0. The first clock after enable rises is a load cycle that always transfers the buffer and clears ldOkFlag.
- R8: centerSel takes effect only at a load cycle. A change in the middle of a period leaves the current pattern unchanged.
- R9: With an active modulus of 0, the count runs 0xFFF down to 0 with dirDown=1 and then reloads. The period is 4096 clocks.
- R10: Reset clears count, dirDown, loadStb and ldOkFlag, but leaves the modulus buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counter run enable |
| centerSel | input | 1 | 1 = center-aligned, 0 = edge-aligned (sampled at load cycles) |
| wrHiEn | input | 1 | Write wrData[3:0] into buffer bits 11..8 |
| wrLoEn | input | 1 | Write wrData into buffer bits 7..0 |
| wrData | input | 8 | Bus write data |
| ldOkSet | input | 1 | Set the load-permit flag |
| rdHi | output | 8 | Buffer high byte readback |
| rdLo | output | 8 | Buffer low byte readback |
| count | output | 12 | Current counter value |
| dirDown | output | 1 | 1 while counting down |
| loadStb | output | 1 | One-clock load-cycle marker |
| activeMod | output | 12 | Modulus in use |
| ldOkFlag | output | 1 | Load-permit flag |

## Verification
Two events can land in the same clock: the permit request and the last clock of a period. The bench provokes this by pulsing ldOkSet exactly when the sampled count equals the modulus. It then expects a load strobe with the old modulus still active and the flag still set, and the new modulus one period later. A second collision puts a buffer byte write into that same final clock while the permit is already set. The transfer must carry the earlier buffer contents, and the readback must show the freshly written byte.

// File: rtl/pwm_period_pkg.sv
package pwm_period_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic take;
    logic stepUp;
    logic stepDown;
    logic centerNext;
  } pbStrobe_t;
endpackage

// File: rtl/pwm_period_dp.sv
module pwm_period_dp
  import pwm_period_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHiEn,
  input  logic              wrLoEn,
  input  logic [BYTE_W-1:0] wrData,
  input  pbStrobe_t         st,
  output logic [BYTE_W-1:0] rdHi,
  output logic [BYTE_W-1:0] rdLo,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  activeMod,
  output logic [CNT_W-1:0]  bufMod
);
  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP  = '1;

  logic [CNT_W-1:0] nextMod;
  logic [CNT_W-1:0] startVal;

  // modulus buffer: deliberately without reset
  always_ff @(posedge clk) begin
    if (wrHiEn) bufMod[CNT_W-1:BYTE_W] <= wrData[HI_W-1:0];
    if (wrLoEn) bufMod[BYTE_W-1:0]     <= wrData;
  end

  assign rdHi = {{(BYTE_W-HI_W){1'b0}}, bufMod[CNT_W-1:BYTE_W]};
  assign rdLo = bufMod[BYTE_W-1:0];

  always_comb begin
    nextMod = st.take ? bufMod : activeMod;
    if (nextMod == ZERO)    startVal = TOP;
    else if (st.centerNext) startVal = ZERO;
    else                    startVal = ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= ZERO;
      activeMod <= ZERO;
    end else begin
      if (st.clear)         count <= ZERO;
      else if (st.load)     count <= startVal;
      else if (st.stepUp)   count <= count + ONE;
      else if (st.stepDown) count <= count - ONE;
      if (st.take) activeMod <= bufMod;
    end
  end

  a_r1_low_byte_readback: assert property (@(posedge clk) disable iff (!rstN)
    wrLoEn |=> rdLo == $past(wrData));

  a_r2_mod_changes_only_on_take: assert property (@(posedge clk) disable iff (!rstN)
    (activeMod != $past(activeMod)) |-> $past(st.take));
endmodule

// File: rtl/pwm_period_ctrl.sv
module pwm_period_ctrl
  import pwm_period_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             centerSel,
  input  logic             ldOkSet,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] activeMod,
  input  logic [CNT_W-1:0] bufMod,
  output pbStrobe_t        st,
  output logic             dirDown,
  output logic             loadStb,
  output logic             ldOkFlag
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP  = '1;

  logic running, centerQ, dirQ, ldOkQ, loadStbQ;
  logic modZero, atEnd, nextModZero, reverse;

  assign modZero     = (activeMod == ZERO);
  assign nextModZero = st.take ? (bufMod == ZERO) : modZero;

  always_comb begin
    if (modZero)      atEnd = (count == ZERO);
    else if (centerQ) atEnd = (dirQ && count == ONE) ||
                              (!dirQ && count == activeMod && activeMod == ONE);
    else              atEnd = (count == activeMod);
  end

  always_comb begin
    st = '0;
    st.centerNext = centerSel;
    if (!enable)      st.clear = 1'b1;
    else if (!running) begin
      st.load = 1'b1;
      st.take = 1'b1;
    end else if (atEnd) begin
      st.load = 1'b1;
      st.take = ldOkQ;
    end else if (modZero || (centerQ && (dirQ || count == activeMod)))
      st.stepDown = 1'b1;
    else
      st.stepUp = 1'b1;
  end

  assign reverse = st.stepDown && centerQ && !dirQ && !modZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      centerQ  <= 1'b0;
      dirQ     <= 1'b0;
      ldOkQ    <= 1'b0;
      loadStbQ <= 1'b0;
    end else begin
      running  <= enable;
      loadStbQ <= st.load;
      if (st.clear) dirQ <= 1'b0;
      else if (st.load) begin
        dirQ    <= nextModZero;
        centerQ <= centerSel;
      end else if (reverse) dirQ <= 1'b1;
      if (ldOkSet)      ldOkQ <= 1'b1;
      else if (st.take) ldOkQ <= 1'b0;
    end
  end

  assign dirDown  = dirQ;
  assign loadStb  = loadStbQ;
  assign ldOkFlag = ldOkQ;

  a_r3_edge_step: assert property (@(posedge clk) disable iff (!rstN)
    (running && enable && !centerQ && !modZero && count != activeMod)
    |=> count == $past(count) + ONE);

  a_r4_center_reverse: assert property (@(posedge clk) disable iff (!rstN)
    (running && enable && centerQ && !dirQ && !modZero && count == activeMod && activeMod != ONE)
    |=> dirDown && count == $past(count) - ONE);

  a_r5_load_start_value: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> count == (modZero ? TOP : (centerQ ? ZERO : ONE)));

  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ldOkSet |=> ldOkFlag);

  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> count == ZERO && !loadStb && !dirDown);

  a_r9_zero_descends: assert property (@(posedge clk) disable iff (!rstN)
    (running && enable && modZero && count != ZERO)
    |=> count == $past(count) - ONE);
endmodule

// File: rtl/pwm_period_base.sv
module pwm_period_base
  import pwm_period_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              centerSel,
  input  logic              wrHiEn,
  input  logic              wrLoEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ldOkSet,
  output logic [BYTE_W-1:0] rdHi,
  output logic [BYTE_W-1:0] rdLo,
  output logic [CNT_W-1:0]  count,
  output logic              dirDown,
  output logic              loadStb,
  output logic [CNT_W-1:0]  activeMod,
  output logic              ldOkFlag
);
  pbStrobe_t        st;
  logic [CNT_W-1:0] bufMod;

  pwm_period_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .centerSel(centerSel),
    .ldOkSet(ldOkSet), .count(count), .activeMod(activeMod), .bufMod(bufMod),
    .st(st), .dirDown(dirDown), .loadStb(loadStb), .ldOkFlag(ldOkFlag)
  );

  pwm_period_dp #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrHiEn(wrHiEn), .wrLoEn(wrLoEn), .wrData(wrData),
    .st(st), .rdHi(rdHi), .rdLo(rdLo), .count(count), .activeMod(activeMod),
    .bufMod(bufMod)
  );
endmodule

// File: tb/pwm_period_base_tb.sv
module pwm_period_base_tb;
  logic clk = 1'b0;
  logic rstN, enable, centerSel, wrHiEn, wrLoEn, ldOkSet;
  logic [7:0]  wrData, rdHi, rdLo;
  logic [11:0] count, activeMod;
  logic dirDown, loadStb, ldOkFlag;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwm_period_base u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .centerSel(centerSel),
    .wrHiEn(wrHiEn), .wrLoEn(wrLoEn), .wrData(wrData), .ldOkSet(ldOkSet),
    .rdHi(rdHi), .rdLo(rdLo), .count(count), .dirDown(dirDown),
    .loadStb(loadStb), .activeMod(activeMod), .ldOkFlag(ldOkFlag)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // called and returns at a negedge
  task automatic writeMod(int v);
    wrHiEn = 1; wrData = 8'((v >> 8) & 15);
    @(negedge clk);
    wrHiEn = 0; wrLoEn = 1; wrData = 8'(v & 255);
    @(negedge clk);
    wrLoEn = 0;
    chk("R1", "rdHi", rdHi, (v >> 8) & 15);
    chk("R1", "rdLo", rdLo, v & 255);
  endtask

  task automatic waitCount(int v);
    for (int i = 0; i < 9000; i++) begin
      if (count == 12'(v)) return;
      @(negedge clk);
    end
  endtask

  task automatic runSweep(bit ctr, int m, int nCyc);
    int per, p, ec, ed;
    writeMod(m);
    centerSel = ctr; enable = 1;
    per = (m == 0) ? 4096 : (ctr ? 2 * m : m);
    for (int k = 0; k < nCyc; k++) begin
      @(negedge clk);
      p = k % per;
      if (m == 0)      begin ec = 4095 - p; ed = 1; end
      else if (ctr)    begin ec = (p <= m) ? p : per - p; ed = (p > m); end
      else             begin ec = 1 + p; ed = 0; end
      if (m == 0) begin
        chk("R9", "count", count, ec);
        chk("R9", "dirDown", dirDown, ed);
      end else if (ctr) begin
        chk("R4", "count", count, ec);
        chk("R4", "dirDown", dirDown, ed);
      end else begin
        chk("R3", "count", count, ec);
        chk("R3", "dirDown", dirDown, ed);
      end
      chk("R5", "loadStb", loadStb, (p == 0));
      chk("R7", "activeMod", activeMod, m);
    end
    enable = 0;
    @(negedge clk);
    chk("R7", "count off", count, 0);
    chk("R7", "loadStb off", loadStb, 0);
    chk("R7", "dirDown off", dirDown, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    rstN = 0; enable = 0; centerSel = 0; wrHiEn = 0; wrLoEn = 0;
    wrData = 0; ldOkSet = 0;
    repeat (3) @(negedge clk);
    chk("R10", "count", count, 0);
    chk("R10", "loadStb", loadStb, 0);
    chk("R10", "ldOkFlag", ldOkFlag, 0);
    chk("R10", "dirDown", dirDown, 0);
    rstN = 1;
    @(negedge clk);

    for (int m = 1; m <= 12; m++) begin
      runSweep(0, m, 2 * m + 3);
      runSweep(1, m, 4 * m + 3);
    end
    runSweep(0, 0, 4096 + 10);
    runSweep(1, 0, 20);

    // R2 / R5: buffered write, then permit
    writeMod(5); centerSel = 0; enable = 1;
    @(negedge clk);
    writeMod(9);
    chk("R2", "active after write", activeMod, 5);
    waitCount(5);
    @(negedge clk);
    chk("R2", "boundary no permit loadStb", loadStb, 1);
    chk("R2", "boundary no permit active", activeMod, 5);
    chk("R1", "rdLo shows buffer", rdLo, 9);
    ldOkSet = 1;
    @(negedge clk);
    ldOkSet = 0;
    chk("R5", "flag set", ldOkFlag, 1);
    waitCount(5);
    @(negedge clk);
    chk("R5", "transfer loadStb", loadStb, 1);
    chk("R5", "transfer active", activeMod, 9);
    chk("R5", "transfer count", count, 1);
    chk("R5", "flag cleared", ldOkFlag, 0);

    // R6: permit in last clock of period
    writeMod(7);
    waitCount(9);
    ldOkSet = 1;
    @(negedge clk);
    ldOkSet = 0;
    chk("R6", "collide loadStb", loadStb, 1);
    chk("R6", "collide active kept", activeMod, 9);
    chk("R6", "collide flag kept", ldOkFlag, 1);
    // R6: buffer write in last clock while permit set
    waitCount(9);
    wrLoEn = 1; wrData = 8'h03;
    @(negedge clk);
    wrLoEn = 0;
    chk("R6", "write collide active", activeMod, 7);
    chk("R6", "write collide flag", ldOkFlag, 0);
    chk("R6", "write collide rdLo", rdLo, 3);
    waitCount(7);
    @(negedge clk);
    chk("R2", "no permit keeps 7", activeMod, 7);
    chk("R2", "no permit loadStb", loadStb, 1);

    // R8: mode change mid-period
    @(negedge clk);
    centerSel = 1;
    @(negedge clk);
    chk("R8", "still edge", count, 3);
    waitCount(7);
    @(negedge clk);
    chk("R8", "center start count", count, 0);
    chk("R8", "center start strobe", loadStb, 1);
    waitCount(7);
    @(negedge clk);
    chk("R8", "center down count", count, 6);
    chk("R8", "center down dir", dirDown, 1);
    enable = 0;
    @(negedge clk);
    chk("R7", "disabled count", count, 0);

    // R7: enable transfers unconditionally and clears permit
    writeMod(4);
    ldOkSet = 1;
    @(negedge clk);
    ldOkSet = 0;
    chk("R7", "flag before enable", ldOkFlag, 1);
    centerSel = 0; enable = 1;
    @(negedge clk);
    chk("R7", "enable transfer", activeMod, 4);
    chk("R7", "enable clears flag", ldOkFlag, 0);
    chk("R7", "enable strobe", loadStb, 1);
    enable = 0;
    @(negedge clk);

    // R10: reset keeps buffer
    writeMod(12'hABC);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    chk("R10", "rdHi kept", rdHi, 8'h0A);
    chk("R10", "rdLo kept", rdLo, 8'hBC);
    chk("R10", "ldOk after reset", ldOkFlag, 0);
    @(negedge clk);
    finish();
  end
endmodule